// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers 64 level-sensitive interrupt lines and turns them into a single outstanding request. The request appears as a 64-bit one-hot vector. Lines 0 to 31 come from bus slots and are enabled in groups of four. Lines 32 to 63 come from on-board sources, and each has its own enable. A 32-bit register port lets software set and clear the enables and acknowledge the request currently shown.

The block latches its inputs on every clock. Once a request is chosen, it stays on the output until software acknowledges it or disables its source. That event triggers a fresh scan, which picks the lowest-numbered line that is both active and enabled. Bus-slot lines are scanned before on-board lines.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `irq_req` has at most one bit set. It is all zeros when no request is outstanding.
- R2: Each mapping register has a single writable bit, bit 31, which is the enable. Bits 30:0 are read-only. A bus-slot group g reads `0x7C0 | (g<<2)` in those bits and an on-board line i reads `0x7E0 + i`. The bus-slot map for group g (lines 4g to 4g+3) is at address `0x000 + 8g + 4`. The on-board map for line i (source 32+i) is at `0x100 + 8i + 4`.
- R3: When nothing is outstanding, the block picks the lowest-numbered line whose latched input is high and whose enable is set. Bus-slot lines 0 to 31 are scanned before on-board lines 32 to 63.
- R4: An outstanding request keeps the same index until it is acknowledged or withdrawn, even if its input drops or a lower-numbered line becomes active.
- R5: Writing a mapping register with bit 31 clear withdraws the outstanding request if that register covers the request's line. A rescan takes place at the same edge.
- R6: A write to the bus-slot clear window at `0x200 + 32g + 4` acknowledges the outstanding request when it is a bus-slot line with index/4 equal to g. A rescan takes place at the same edge.
- R7: A write to the on-board clear register at `0x300 + 8i + 4` acknowledges the outstanding request only when its index is exactly 32+i. A rescan takes place at the same edge.
- R8: Mapping and clear registers respond only when address bit 2 is set. Writes with bit 2 clear have no effect, and reads with bit 2 clear, reads of clear registers, and reads of unmapped addresses return zero.
- R9: After reset every enable is clear and no request is outstanding.
- R10: Reset while lines are active and enabled drops the request and clears both the enables and the latched input vector.
- R11: An input that rises before clock edge k is latched at edge k. It can be shown on `irq_req` from edge k+1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lvl | input | 64 | Level interrupt inputs, bus-slot 0..31 and on-board 32..63 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register byte address |
| cfg_wdata | input | 32 | Register write data (only bit 31 is used) |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| irq_req | output | 64 | One-hot outstanding request |

## Verification
The hardest situation to reach is an acknowledge or withdraw that lands while another enabled line is already active. Only then does the same-edge rescan have to hand the output straight to a new line, with no idle cycle in between. Group acknowledges must also discriminate correctly between lines in the same group and lines in a neighbouring group. Directed steps set up both cases: two sources active at once, a mismatched on-board acknowledge, and a bus group release that must fall through to an on-board line. A long random run then toggles input bits sparsely and mixes map writes, clear writes and lower-word writes. This lets acknowledges and withdrawals collide with pending lines in many orders.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and helpers for the prioritized interrupt controller.
// Assumes a 10-bit byte address split into four 256-byte windows by bits 9:8.
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        WIN_BUS_MAP = 2'd0,
        WIN_OB_MAP  = 2'd1,
        WIN_BUS_CLR = 2'd2,
        WIN_OB_CLR  = 2'd3
    } win_e;

    localparam int unsigned CFG_AW      = 10;
    localparam logic [30:0] BUS_MAP_TAG = 31'h7C0;
    localparam logic [30:0] OB_MAP_TAG  = 31'h7E0;

    // Read-only low bits of a bus-slot group map register.
    function automatic logic [30:0] bus_map_low(input logic [4:0] grp);
        return BUS_MAP_TAG | {24'd0, grp, 2'b00};
    endfunction

    // Read-only low bits of an on-board line map register.
    function automatic logic [30:0] ob_map_low(input logic [4:0] line);
        return OB_MAP_TAG + {26'd0, line};
    endfunction

endpackage

// File: rtl/irq_prio_scan.sv
// Module: fixed-priority finder, lowest set index wins.
// Assumes N is a power of two and IW = log2(N). Purely combinational.
module irq_prio_scan #(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] pick
);

    // Walk from the top down so the lowest active index is written last.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                pick  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_map_regs.sv
// Module: enable bits of the group and per-line mapping registers.
// Only bit 31 of each register is stored; the low bits are constants.
// Provides both current and next-cycle enables so a same-edge rescan
// sees a write that lands at that edge. Assumes GW, OW <= 5.
module irq_map_regs
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_GRP = 8,
    parameter int unsigned NUM_OB  = 32,
    localparam int unsigned GW     = $clog2(NUM_GRP),
    localparam int unsigned OW     = $clog2(NUM_OB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [GW-1:0]      bus_sel,
    input  logic               ob_we,
    input  logic [OW-1:0]      ob_sel,
    input  logic               wr_en_bit,
    input  logic               rd_bus,
    input  logic               rd_ob,
    input  logic [GW-1:0]      rd_bus_sel,
    input  logic [OW-1:0]      rd_ob_sel,
    output logic [NUM_GRP-1:0] bus_en_q,
    output logic [NUM_OB-1:0]  ob_en_q,
    output logic [NUM_GRP-1:0] bus_en_d,
    output logic [NUM_OB-1:0]  ob_en_d,
    output logic [31:0]        rd_val
);

    // Next-state enables: the selected bit takes the written enable value.
    always_comb begin
        bus_en_d = bus_en_q;
        ob_en_d  = ob_en_q;
        if (bus_we) bus_en_d[bus_sel] = wr_en_bit;
        if (ob_we)  ob_en_d[ob_sel]   = wr_en_bit;
    end

    // Enable storage, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_en_q <= '0;
            ob_en_q  <= '0;
        end else begin
            bus_en_q <= bus_en_d;
            ob_en_q  <= ob_en_d;
        end
    end

    // Read path: stored enable over the constant low field.
    always_comb begin
        rd_val = 32'd0;
        if (rd_bus)
            rd_val = {bus_en_q[rd_bus_sel], bus_map_low(5'(rd_bus_sel))};
        else if (rd_ob)
            rd_val = {ob_en_q[rd_ob_sel], ob_map_low(5'(rd_ob_sel))};
    end

    AST_GRP_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> bus_en_q[$past(bus_sel)] == $past(wr_en_bit)); // R2
    AST_LINE_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ob_we |=> ob_en_q[$past(ob_sel)] == $past(wr_en_bit)); // R2

endmodule

// File: rtl/irq_req_track.sv
// Module: holds the single outstanding request and decides when to rescan.
// A withdraw (enable cleared on the covering map register) or a matching
// acknowledge releases the request; the scan result is loaded at the same
// edge whenever the slot is empty or being released.
module irq_req_track #(
    parameter int unsigned NUM_GRP = 8,
    parameter int unsigned LPG     = 4,
    parameter int unsigned NUM_OB  = 32,
    localparam int unsigned NUM_BUS = NUM_GRP * LPG,
    localparam int unsigned NUM_SRC = NUM_BUS + NUM_OB,
    localparam int unsigned IW      = $clog2(NUM_SRC),
    localparam int unsigned GW      = $clog2(NUM_GRP),
    localparam int unsigned OW      = $clog2(NUM_OB),
    localparam int unsigned LW      = $clog2(LPG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_map_we,
    input  logic [GW-1:0]      bus_map_sel,
    input  logic               ob_map_we,
    input  logic [OW-1:0]      ob_map_sel,
    input  logic               wr_en_bit,
    input  logic               bus_clr_we,
    input  logic [GW-1:0]      bus_clr_sel,
    input  logic               ob_clr_we,
    input  logic [OW-1:0]      ob_clr_sel,
    input  logic               scan_found,
    input  logic [IW-1:0]      scan_pick,
    output logic               req_vld,
    output logic [IW-1:0]      req_idx,
    output logic [NUM_SRC-1:0] req_onehot
);

    localparam logic [IW-1:0] BUS_LIM = IW'(NUM_BUS);

    logic          req_vld_q;
    logic [IW-1:0] req_idx_q;
    logic          req_is_bus;
    logic [IW-1:0] req_grp;
    logic [IW-1:0] req_line;
    logic          release_now;

    // Locate the outstanding request inside its group or line space.
    always_comb begin
        req_is_bus = req_idx_q < BUS_LIM;
        req_grp    = req_idx_q >> LW;
        req_line   = req_idx_q - BUS_LIM;
    end

    // Release on a withdrawing map write or a matching acknowledge.
    always_comb begin
        release_now = 1'b0;
        if (req_vld_q) begin
            if (bus_map_we && !wr_en_bit && req_is_bus && req_grp == IW'(bus_map_sel))
                release_now = 1'b1;
            if (ob_map_we && !wr_en_bit && !req_is_bus && req_line == IW'(ob_map_sel))
                release_now = 1'b1;
            if (bus_clr_we && req_is_bus && req_grp == IW'(bus_clr_sel))
                release_now = 1'b1;
            if (ob_clr_we && !req_is_bus && req_line == IW'(ob_clr_sel))
                release_now = 1'b1;
        end
    end

    // Request slot: load a new scan result only when empty or released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vld_q <= 1'b0;
            req_idx_q <= '0;
        end else if (!req_vld_q || release_now) begin
            req_vld_q <= scan_found;
            req_idx_q <= scan_pick;
        end
    end

    // One-hot expansion of the request slot.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_onehot
        assign req_onehot[s] = req_vld_q && (req_idx_q == IW'(s));
    end

    assign req_vld = req_vld_q;
    assign req_idx = req_idx_q;

    AST_EMPTY_LOADS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_q && scan_found |=> req_vld_q && req_idx_q == $past(scan_pick)); // R3

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized interrupt request controller.
// Latches 64 level inputs, decodes the register port into map writes,
// clear writes and reads, builds the per-line enable vector and feeds the
// priority scan and the request tracker. Reads are combinational.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_GRP = 8,
    parameter int unsigned LPG     = 4,
    parameter int unsigned NUM_OB  = 32,
    localparam int unsigned NUM_BUS = NUM_GRP * LPG,
    localparam int unsigned NUM_SRC = NUM_BUS + NUM_OB,
    localparam int unsigned IW      = $clog2(NUM_SRC),
    localparam int unsigned GW      = $clog2(NUM_GRP),
    localparam int unsigned OW      = $clog2(NUM_OB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lvl,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic [NUM_SRC-1:0] irq_req
);

    localparam logic [4:0] GRP_LIM5 = 5'(NUM_GRP - 1);
    localparam logic [2:0] GRP_LIM3 = 3'(NUM_GRP - 1);
    localparam logic [4:0] OB_LIM5  = 5'(NUM_OB - 1);

    logic [NUM_SRC-1:0] lvl_q;
    win_e               win;
    logic               hi_word;
    logic [4:0]         slot5;
    logic [2:0]         gslot3;
    logic               bus_map_hit, ob_map_hit, bus_clr_hit, ob_clr_hit;
    logic [NUM_GRP-1:0] bus_en_q, bus_en_d;
    logic [NUM_OB-1:0]  ob_en_q, ob_en_d;
    logic [NUM_SRC-1:0] src_en_q, src_en_d;
    logic [NUM_SRC-1:0] scan_vec;
    logic               scan_found;
    logic [IW-1:0]      scan_pick;
    logic               req_vld;
    logic [IW-1:0]      req_idx;
    logic               unused_cfg;

    assign unused_cfg = ^{cfg_wdata[30:0], cfg_addr[1:0]};

    // Latch the level inputs once per clock; reset empties the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= irq_lvl;
    end

    // Address decode: window, upper-word qualifier and slot indices.
    always_comb begin
        win         = win_e'(cfg_addr[9:8]);
        hi_word     = cfg_addr[2];
        slot5       = cfg_addr[7:3];
        gslot3      = cfg_addr[7:5];
        bus_map_hit = hi_word && (win == WIN_BUS_MAP) && (slot5 <= GRP_LIM5);
        ob_map_hit  = hi_word && (win == WIN_OB_MAP)  && (slot5 <= OB_LIM5);
        bus_clr_hit = hi_word && (win == WIN_BUS_CLR) && (gslot3 <= GRP_LIM3);
        ob_clr_hit  = hi_word && (win == WIN_OB_CLR)  && (slot5 <= OB_LIM5);
    end

    irq_map_regs #(
        .NUM_GRP (NUM_GRP),
        .NUM_OB  (NUM_OB)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (cfg_we && bus_map_hit),
        .bus_sel    (slot5[GW-1:0]),
        .ob_we      (cfg_we && ob_map_hit),
        .ob_sel     (slot5[OW-1:0]),
        .wr_en_bit  (cfg_wdata[31]),
        .rd_bus     (bus_map_hit),
        .rd_ob      (ob_map_hit),
        .rd_bus_sel (slot5[GW-1:0]),
        .rd_ob_sel  (slot5[OW-1:0]),
        .bus_en_q   (bus_en_q),
        .ob_en_q    (ob_en_q),
        .bus_en_d   (bus_en_d),
        .ob_en_d    (ob_en_d),
        .rd_val     (cfg_rdata)
    );

    // Spread group and line enables onto the 64 source positions.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_en
        if (s < NUM_BUS) begin : g_bus
            assign src_en_d[s] = bus_en_d[s / LPG];
            assign src_en_q[s] = bus_en_q[s / LPG];
        end else begin : g_ob
            assign src_en_d[s] = ob_en_d[s - NUM_BUS];
            assign src_en_q[s] = ob_en_q[s - NUM_BUS];
        end
    end

    assign scan_vec = lvl_q & src_en_d;

    irq_prio_scan #(
        .N  (NUM_SRC),
        .IW (IW)
    ) u_scan (
        .vec   (scan_vec),
        .found (scan_found),
        .pick  (scan_pick)
    );

    irq_req_track #(
        .NUM_GRP (NUM_GRP),
        .LPG     (LPG),
        .NUM_OB  (NUM_OB)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_map_we  (cfg_we && bus_map_hit),
        .bus_map_sel (slot5[GW-1:0]),
        .ob_map_we   (cfg_we && ob_map_hit),
        .ob_map_sel  (slot5[OW-1:0]),
        .wr_en_bit   (cfg_wdata[31]),
        .bus_clr_we  (cfg_we && bus_clr_hit),
        .bus_clr_sel (gslot3[GW-1:0]),
        .ob_clr_we   (cfg_we && ob_clr_hit),
        .ob_clr_sel  (slot5[OW-1:0]),
        .scan_found  (scan_found),
        .scan_pick   (scan_pick),
        .req_vld     (req_vld),
        .req_idx     (req_idx),
        .req_onehot  (irq_req)
    );

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req)); // R1
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !cfg_we |=> req_vld && $stable(req_idx)); // R4
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> src_en_q[req_idx]); // R5
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        scan_found |-> scan_vec[scan_pick] &&
            ((scan_vec & ((NUM_SRC'(1) << scan_pick) - NUM_SRC'(1))) == '0)); // R3

endmodule

// File: tb/irq_prio_ctrl_tb.sv
// Bench: directed corners plus seeded random stimulus, checked against a
// reference model built from the requirements.
module irq_prio_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lvl = '0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] irq_req;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [63:0] m_lvl = '0;
    logic [7:0]  m_ben = '0;
    logic [31:0] m_oen = '0;
    logic        m_v = 1'b0;
    int          m_i = 0;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_req(irq_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic en_of(input logic [7:0] b, input logic [31:0] o, input int j);
        if (j < 32) return b[j / 4];
        return o[j - 32];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [9:0] a);
        if (!a[2]) return 32'd0;
        if (a[9:8] == 2'd0 && a[7:6] == 2'd0)
            return {m_ben[a[5:3]], 31'h7C0 | {26'd0, a[5:3], 2'b00}};
        if (a[9:8] == 2'd1)
            return {m_oen[a[7:3]], 31'h7E0 + {26'd0, a[7:3]}};
        return 32'd0;
    endfunction

    function automatic logic [63:0] exp_req();
        if (!m_v) return 64'd0;
        return 64'd1 << m_i;
    endfunction

    // Advance the model by one clock edge using the values driven before it.
    task automatic model_edge();
        logic [7:0]  nb = m_ben;
        logic [31:0] no = m_oen;
        logic        clr = 1'b0;
        logic        fnd = 1'b0;
        int          pk = 0;
        if (cfg_we && cfg_addr[2]) begin
            case (cfg_addr[9:8])
                2'd0: if (cfg_addr[7:6] == 2'd0) begin
                    nb[cfg_addr[5:3]] = cfg_wdata[31];
                    if (!cfg_wdata[31] && m_v && m_i < 32 && m_i / 4 == int'(cfg_addr[5:3])) clr = 1'b1;
                end
                2'd1: begin
                    no[cfg_addr[7:3]] = cfg_wdata[31];
                    if (!cfg_wdata[31] && m_v && m_i == 32 + int'(cfg_addr[7:3])) clr = 1'b1;
                end
                2'd2: if (m_v && m_i < 32 && m_i / 4 == int'(cfg_addr[7:5])) clr = 1'b1;
                default: if (m_v && m_i == 32 + int'(cfg_addr[7:3])) clr = 1'b1;
            endcase
        end
        if (!m_v || clr) begin
            for (int j = 0; j < 64; j++)
                if (!fnd && m_lvl[j] && en_of(nb, no, j)) begin fnd = 1'b1; pk = j; end
            m_v = fnd;
            m_i = pk;
        end
        m_lvl = irq_lvl;
        m_ben = nb;
        m_oen = no;
    endtask

    task automatic step(input logic [63:0] lv, input logic we, input logic [9:0] a, input logic [31:0] d);
        irq_lvl = lv; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_req(input string tag);
        n_chk++;
        if (irq_req !== exp_req()) begin
            n_bad++;
            $display("FAIL %s irq_req actual=%h expected=%h", tag, irq_req, exp_req());
        end
    endtask

    task automatic chk_rd(input logic [9:0] a, input string tag);
        cfg_addr = a;
        #1;
        n_chk++;
        if (cfg_rdata !== exp_rd(a)) begin
            n_bad++;
            $display("FAIL %s rdata@%h actual=%h expected=%h", tag, a, cfg_rdata, exp_rd(a));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        m_lvl = '0; m_ben = '0; m_oen = '0; m_v = 1'b0; m_i = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] lv;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();

        // R9: reset state of request and map registers
        chk_req("R9");
        for (int g = 0; g < 8; g++) chk_rd(10'(8 * g + 4), "R9");
        for (int i = 0; i < 32; i++) chk_rd(10'(10'h100 + 8 * i + 4), "R9");
        // R8: lower words and clear windows read zero
        chk_rd(10'h008, "R8");
        chk_rd(10'h224, "R8");

        // R2: enable group 1 with junk low bits, they must not change
        step(64'd0, 1'b1, 10'h00C, 32'hFFFF_FFFF);
        chk_rd(10'h00C, "R2");
        step(64'd0, 1'b1, 10'h12C, 32'h8000_0000); // on-board line 5
        chk_rd(10'h12C, "R2");
        // R8: lower-word write is ignored
        step(64'd0, 1'b1, 10'h130, 32'h8000_0000);
        chk_rd(10'h134, "R8");

        // R11: line 6 and line 37 rise together; latched, not yet shown
        lv = (64'd1 << 6) | (64'd1 << 37);
        step(lv, 1'b0, 10'h0, 32'h0);
        chk_req("R11");
        step(lv, 1'b0, 10'h0, 32'h0);
        chk_req("R3");  // bus-slot line 6 wins over line 37
        // R4: drop line 6 and raise line 4; request must stay on 6
        lv = (64'd1 << 4) | (64'd1 << 37);
        step(lv, 1'b0, 10'h0, 32'h0);
        step(lv, 1'b0, 10'h0, 32'h0);
        chk_req("R4");
        // R7: on-board ack for line 37 must not release bus line 6
        step(lv, 1'b1, 10'h32C, 32'h0);
        chk_req("R7");
        // R6: wrong group ack is ignored, right group releases; line 4 next
        step(lv, 1'b1, 10'h204, 32'h0);
        chk_req("R6");
        step(lv, 1'b1, 10'h224, 32'h0);
        chk_req("R6");
        // R5: disable group 1 while line 4 outstanding -> falls to line 37
        step(lv, 1'b1, 10'h00C, 32'h0);
        chk_req("R5");
        // R7: exact on-board ack releases line 37, re-picked as still high
        step(lv, 1'b1, 10'h32C, 32'h0);
        chk_req("R7");
        // R5: withdraw line 37 by disabling its map
        step(lv, 1'b1, 10'h12C, 32'h0);
        chk_req("R5");
        step(lv, 1'b0, 10'h0, 32'h0);
        chk_req("R1");

        // R10: reset with active enabled lines
        step(lv, 1'b1, 10'h12C, 32'h8000_0000);
        step(lv, 1'b0, 10'h0, 32'h0);
        chk_req("R10");
        do_reset();
        chk_req("R10");
        chk_rd(10'h12C, "R10");
        step(64'd0, 1'b1, 10'h12C, 32'h8000_0000);
        chk_req("R10"); // latched vector was emptied, nothing to pick

        // Random phase
        lv = '0;
        for (int n = 0; n < 4000; n++) begin
            logic [9:0]  a;
            logic [31:0] d;
            logic        we;
            if ($urandom_range(0, 3) == 0) lv ^= (64'd1 << $urandom_range(0, 63));
            we = ($urandom_range(0, 9) < 3);
            a = {2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)), ($urandom_range(0, 4) != 0), 2'b00};
            if (a[9:8] == 2'd0) a[7:6] = 2'b00;
            d = {1'($urandom_range(0, 1)), 31'($urandom)};
            step(lv, we, a, d);
            chk_req("R3/R4");
            chk_rd({2'($urandom_range(0, 3)), 8'($urandom)}, "R8");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule